// File: doc/BRIEF.md
# Inclusive Coherence Directory Slice

This block is one slice of an on-chip coherence directory. It records, for every memory line held by any of the private caches it serves, a directory state and the set of caches that may hold a copy. The directory is a small set-associative array and is inclusive of the private caches. A lookup miss, or an entry in state I, therefore means that no cache holds the line. State S means that one or more caches may hold it shared. State X means that a single owner may hold it modified, exclusive or shared.

Each request names a cache, a line address and an operation: read, read-for-ownership, writeback, or eviction notice. The slice looks up the line, allocates an entry if the request needs one, and updates the state and holder record. It then returns one action. The action lists the caches to invalidate, states whether the request is forwarded to the current owner (and which cache that is), and states whether memory must supply the data. The holder record has three forms, chosen by parameter `SHR_MODE`. Mode 0 keeps one bit per cache. Mode 1 keeps one bit per group of `GROUP` caches. Mode 2 keeps `PTRS` explicit cache IDs plus an overflow flag. When a full set must take a new line, the slice first emits a back-invalidation action for the victim entry, which keeps the directory inclusive.

Control is a four-state machine:
- ST_IDLE accepts a request and moves to ST_LOOK.
- ST_LOOK moves to ST_BINV when a victim must be removed, or otherwise writes the entry and moves to ST_RESP.
- ST_BINV returns to ST_LOOK once its action is taken.
- ST_RESP returns to ST_IDLE once its action is taken.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `act_valid` is 0 and every entry is in state I. Each accepted request yields exactly one action with `act_backinv`=0.
- R2: A read (`req_op`=0) that misses or finds state I allocates the entry in X with the requester as owner. The action has `act_mem_read`=1, no forward and an empty invalidation mask.
- R3: A read that finds X with another owner moves the entry to S holding both caches. The action has `act_fwd`=1, `act_fwd_cid` set to the owner, and `act_mem_read`=0.
- R4: A read that finds S adds the requester as a holder. The action has `act_mem_read`=1, no forward and an empty mask; a read by the X owner itself also gets `act_mem_read`=1.
- R5: A read-for-ownership (`req_op`=1) leaves the entry in X owned by the requester. Bit i of `act_inv_mask` stands for cache i, and the mask lists every recorded holder except the requester. If the previous state was X with another owner, the action has `act_fwd`=1 and `act_mem_read`=0. If the previous state was I or S, it has `act_mem_read`=1.
- R6: A writeback (`req_op`=2) from the X owner returns the entry to I. A writeback from any other cache, or to a line with no entry, changes nothing. Every writeback action has no forward, no memory read and an empty mask.
- R7: An eviction notice (`req_op`=3) from the X owner returns the entry to I. From an S holder, it removes that cache, and removing the last recorded holder returns the entry to I.
- R8: In coarse mode an invalidation covers every cache of each marked group except the requester, and an eviction notice cannot clear a group bit when `GROUP`>1.
- R9: In pointer mode, a new holder that finds all slots in use sets the overflow flag. While the flag is set, invalidations go to every cache except the requester and eviction notices leave the record unchanged.
- R10: When a read or read-for-ownership misses and every way of the set is out of state I, the slice first emits an action with `act_backinv`=1. That action carries the victim's address and holder mask, and the victim is set to I. The response for the request follows.
- R11: The set index is the low log2(`SETS`) bits of the address. A way in state I is taken for allocation before any other way, lowest index first. Otherwise the victim is the pseudo-LRU way of a binary tree that every hit and allocation updates.
- R12: While `act_valid` is 1 and `act_ready` is 0, the action fields hold steady and `req_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice idle and able to take a request |
| req_op | input | 2 | 0 read, 1 read-for-ownership, 2 writeback, 3 eviction notice |
| req_cid | input | CID_W | Requesting cache number |
| req_addr | input | ADDR_W | Line address |
| act_valid | output | 1 | Action present |
| act_ready | input | 1 | Action taken by the interconnect side |
| act_backinv | output | 1 | Action is a back-invalidation of a replaced entry |
| act_addr | output | ADDR_W | Line the action applies to |
| act_cid | output | CID_W | Requester of the request being served |
| act_inv_mask | output | N_CACHE | Caches that must invalidate the line |
| act_fwd | output | 1 | Forward the request to the owner |
| act_fwd_cid | output | CID_W | Owner to forward to |
| act_mem_read | output | 1 | Memory supplies the data |

## Verification
The assertions assume four things about the inputs. Every cache number on `req_cid` lies below `N_CACHE`. Request fields hold steady while `req_valid` is high. Caches send writebacks and eviction notices only for lines the protocol allows them to have. `act_ready` is eventually raised. The stimulus keeps within these limits: it uses caches 0 to 7 of eight, sets the request fields before it raises valid, and follows legal coherence sequences. Backpressure is applied to only one instance, and only for a bounded number of cycles.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DIR_I = 2'd0,
        DIR_S = 2'd1,
        DIR_X = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_RFO   = 2'd1,
        OP_WB    = 2'd2,
        OP_EVICT = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        HC_SET = 2'd0,
        HC_ADD = 2'd1,
        HC_REM = 2'd2
    } hcmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_BINV = 2'd2,
        ST_RESP = 2'd3
    } fsm_e;

    // Width of the holder record for each encoding.
    function automatic int holder_w(int mode, int n, int grp, int ptrs, int cidw);
        if (mode == 0) return n;
        if (mode == 1) return n / grp;
        return ptrs * (cidw + 1) + 1;
    endfunction

endpackage

// File: rtl/coh_dir_sharer.sv
module coh_dir_sharer
    import coh_dir_pkg::*;
#(
    parameter int N_CACHE = 8,
    parameter int CID_W   = 3,
    parameter int MODE    = 0,
    parameter int GROUP   = 2,
    parameter int PTRS    = 2,
    parameter int HW      = 8
) (
    input  logic [HW-1:0]      hold_i,
    input  logic [HW-1:0]      vic_hold_i,
    input  logic [CID_W-1:0]   cid_i,
    input  hcmd_e              cmd_i,
    output logic [HW-1:0]      hold_o,
    output logic [N_CACHE-1:0] mask_o,
    output logic [N_CACHE-1:0] vic_mask_o,
    output logic               empty_o
);

    generate
        if (MODE == 0) begin : g_full
            always_comb begin
                hold_o = hold_i;
                unique case (cmd_i)
                    HC_SET:  begin hold_o = '0; hold_o[cid_i] = 1'b1; end
                    HC_ADD:  hold_o[cid_i] = 1'b1;
                    default: hold_o[cid_i] = 1'b0;
                endcase
                mask_o     = hold_i;
                vic_mask_o = vic_hold_i;
                empty_o    = (hold_o == '0);
            end
        end else if (MODE == 1) begin : g_coarse
            always_comb begin
                int grp;
                grp    = int'(cid_i) / GROUP;
                hold_o = hold_i;
                unique case (cmd_i)
                    HC_SET:  begin hold_o = '0; hold_o[grp] = 1'b1; end
                    HC_ADD:  hold_o[grp] = 1'b1;
                    default: if (GROUP == 1) hold_o[grp] = 1'b0;
                endcase
                for (int i = 0; i < N_CACHE; i++) begin
                    mask_o[i]     = hold_i[i / GROUP];
                    vic_mask_o[i] = vic_hold_i[i / GROUP];
                end
                empty_o = (hold_o == '0);
            end
        end else begin : g_ptr
            localparam int VB = PTRS * CID_W;

            function automatic logic [N_CACHE-1:0] expand(logic [HW-1:0] h);
                logic [N_CACHE-1:0] m;
                m = '0;
                if (h[HW-1]) begin
                    m = '1;
                end else begin
                    for (int s = 0; s < PTRS; s++)
                        if (h[VB + s]) m[h[s*CID_W +: CID_W]] = 1'b1;
                end
                return m;
            endfunction

            always_comb begin
                logic found;
                logic placed;
                found  = 1'b0;
                placed = 1'b0;
                hold_o = hold_i;
                unique case (cmd_i)
                    HC_SET: begin
                        hold_o = '0;
                        hold_o[0 +: CID_W] = cid_i;
                        hold_o[VB] = 1'b1;
                    end
                    HC_ADD: begin
                        if (!hold_i[HW-1]) begin
                            for (int s = 0; s < PTRS; s++)
                                if (hold_i[VB + s] && hold_i[s*CID_W +: CID_W] == cid_i)
                                    found = 1'b1;
                            if (!found) begin
                                for (int s = 0; s < PTRS; s++) begin
                                    if (!placed && !hold_i[VB + s]) begin
                                        hold_o[s*CID_W +: CID_W] = cid_i;
                                        hold_o[VB + s] = 1'b1;
                                        placed = 1'b1;
                                    end
                                end
                                if (!placed) hold_o[HW-1] = 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (!hold_i[HW-1]) begin
                            for (int s = 0; s < PTRS; s++)
                                if (hold_i[VB + s] && hold_i[s*CID_W +: CID_W] == cid_i)
                                    hold_o[VB + s] = 1'b0;
                        end
                    end
                endcase
                mask_o     = expand(hold_i);
                vic_mask_o = expand(vic_hold_i);
                empty_o    = !hold_o[HW-1] && (hold_o[VB +: PTRS] == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/coh_dir_plru.sv
module coh_dir_plru #(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    input  logic                     touch_en,
    input  logic [$clog2(SETS)-1:0]  touch_set,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    output logic [$clog2(WAYS)-1:0]  victim_o
);

    localparam int WAY_W = $clog2(WAYS);

    // Heap-ordered tree bits; a 1 points the victim walk to the upper half.
    logic [WAYS-2:0] tree_q [SETS];
    logic [WAYS-2:0] tree_nxt;

    always_comb begin
        int node;
        node = 1;
        for (int l = 0; l < WAY_W; l++)
            node = node * 2 + (tree_q[rd_set][node-1] ? 1 : 0);
        victim_o = WAY_W'(node - WAYS);
    end

    always_comb begin
        int node;
        node     = 1;
        tree_nxt = tree_q[touch_set];
        for (int l = 0; l < WAY_W; l++) begin
            tree_nxt[node-1] = !touch_way[WAY_W-1-l];
            node = node * 2 + (touch_way[WAY_W-1-l] ? 1 : 0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_nxt;
        end
    end

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int N_CACHE  = 8,
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int ADDR_W   = 12,
    parameter int SHR_MODE = 0,
    parameter int GROUP    = 2,
    parameter int PTRS     = 2,
    localparam int CID_W   = $clog2(N_CACHE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [CID_W-1:0]    req_cid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                act_valid,
    input  logic                act_ready,
    output logic                act_backinv,
    output logic [ADDR_W-1:0]   act_addr,
    output logic [CID_W-1:0]    act_cid,
    output logic [N_CACHE-1:0]  act_inv_mask,
    output logic                act_fwd,
    output logic [CID_W-1:0]    act_fwd_cid,
    output logic                act_mem_read
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int HW    = holder_w(SHR_MODE, N_CACHE, GROUP, PTRS, CID_W);

    fsm_e st_q, st_d;

    req_op_e            rq_op;
    logic [CID_W-1:0]   rq_cid;
    logic [ADDR_W-1:0]  rq_addr;

    dir_state_e         ds_q   [SETS][WAYS];
    logic [TAG_W-1:0]   tag_q  [SETS][WAYS];
    logic [CID_W-1:0]   own_q  [SETS][WAYS];
    logic [HW-1:0]      hold_q [SETS][WAYS];

    logic                a_binv, a_fwd, a_mem;
    logic [ADDR_W-1:0]   a_addr;
    logic [N_CACHE-1:0]  a_inv;
    logic [CID_W-1:0]    a_fcid;

    // ---------------- lookup ----------------
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_in;
    logic [WAYS-1:0]   hit_vec, free_vec;
    logic [WAY_W-1:0]  hit_way, free_way, alloc_way, way_sel, plru_vic;
    logic              hit, has_free, need_alloc, need_binv;
    dir_state_e        cur_st;
    logic [CID_W-1:0]  cur_own;
    logic [HW-1:0]     cur_hold, vic_hold, new_hold;
    logic [N_CACHE-1:0] cur_mask, vic_mask, req_bit;
    logic              new_empty;

    assign set_idx = rq_addr[IDX_W-1:0];
    assign tag_in  = rq_addr[ADDR_W-1:IDX_W];
    assign req_bit = N_CACHE'(1) << rq_cid;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w]  = (ds_q[set_idx][w] != DIR_I) && (tag_q[set_idx][w] == tag_in);
            free_vec[w] = (ds_q[set_idx][w] == DIR_I);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way  = WAY_W'(w);
            if (free_vec[w]) free_way = WAY_W'(w);
        end
        hit        = |hit_vec;
        has_free   = |free_vec;
        alloc_way  = has_free ? free_way : plru_vic;
        way_sel    = hit ? hit_way : alloc_way;
        need_alloc = !hit && (rq_op == OP_READ || rq_op == OP_RFO);
        need_binv  = need_alloc && !has_free;
        cur_st     = hit ? ds_q[set_idx][way_sel] : DIR_I;
        cur_own    = own_q[set_idx][way_sel];
        cur_hold   = hold_q[set_idx][way_sel];
        vic_hold   = hold_q[set_idx][alloc_way];
    end

    // ---------------- protocol decision ----------------
    hcmd_e              hcmd;
    logic               wr_en;
    dir_state_e         nx_st;
    logic [CID_W-1:0]   nx_own;
    logic [N_CACHE-1:0] d_inv;
    logic               d_fwd, d_mem;

    coh_dir_sharer #(
        .N_CACHE(N_CACHE), .CID_W(CID_W), .MODE(SHR_MODE),
        .GROUP(GROUP), .PTRS(PTRS), .HW(HW)
    ) u_sharer (
        .hold_i     (cur_hold),
        .vic_hold_i (vic_hold),
        .cid_i      (rq_cid),
        .cmd_i      (hcmd),
        .hold_o     (new_hold),
        .mask_o     (cur_mask),
        .vic_mask_o (vic_mask),
        .empty_o    (new_empty)
    );

    always_comb begin
        hcmd   = HC_ADD;
        wr_en  = 1'b0;
        nx_st  = cur_st;
        nx_own = cur_own;
        d_inv  = '0;
        d_fwd  = 1'b0;
        d_mem  = 1'b0;
        unique case (rq_op)
            OP_READ: begin
                if (cur_st == DIR_I) begin
                    nx_st = DIR_X; nx_own = rq_cid; hcmd = HC_SET; wr_en = 1'b1; d_mem = 1'b1;
                end else if (cur_st == DIR_X && cur_own != rq_cid) begin
                    nx_st = DIR_S; hcmd = HC_ADD; wr_en = 1'b1; d_fwd = 1'b1;
                end else if (cur_st == DIR_S) begin
                    hcmd = HC_ADD; wr_en = 1'b1; d_mem = 1'b1;
                end else begin
                    d_mem = 1'b1;
                end
            end
            OP_RFO: begin
                if (!(cur_st == DIR_X && cur_own == rq_cid)) begin
                    nx_st  = DIR_X; nx_own = rq_cid; hcmd = HC_SET; wr_en = 1'b1;
                    d_inv  = (cur_st == DIR_I) ? '0 : (cur_mask & ~req_bit);
                    d_fwd  = (cur_st == DIR_X);
                    d_mem  = (cur_st != DIR_X);
                end
            end
            OP_WB: begin
                if (cur_st == DIR_X && cur_own == rq_cid) begin
                    nx_st = DIR_I; wr_en = 1'b1;
                end
            end
            default: begin
                if (cur_st == DIR_X && cur_own == rq_cid) begin
                    nx_st = DIR_I; wr_en = 1'b1;
                end else if (cur_st == DIR_S) begin
                    hcmd = HC_REM; wr_en = 1'b1;
                    if (new_empty) nx_st = DIR_I;
                end
            end
        endcase
    end

    coh_dir_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (set_idx),
        .touch_en  ((st_q == ST_LOOK) && !need_binv && (hit || need_alloc)),
        .touch_set (set_idx),
        .touch_way (way_sel),
        .victim_o  (plru_vic)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_LOOK;
            ST_LOOK: st_d = need_binv ? ST_BINV : ST_RESP;
            ST_BINV: if (act_ready) st_d = ST_LOOK;
            ST_RESP: if (act_ready) st_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        act_valid    = (st_q == ST_BINV) || (st_q == ST_RESP);
        act_backinv  = a_binv;
        act_addr     = a_addr;
        act_cid      = rq_cid;
        act_inv_mask = a_inv;
        act_fwd      = a_fwd;
        act_fwd_cid  = a_fcid;
        act_mem_read = a_mem;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_op   <= OP_READ;
            rq_cid  <= '0;
            rq_addr <= '0;
            a_binv  <= 1'b0;
            a_addr  <= '0;
            a_inv   <= '0;
            a_fwd   <= 1'b0;
            a_fcid  <= '0;
            a_mem   <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ds_q[s][w]   <= DIR_I;
                    tag_q[s][w]  <= '0;
                    own_q[s][w]  <= '0;
                    hold_q[s][w] <= '0;
                end
            end
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                rq_op   <= req_op_e'(req_op);
                rq_cid  <= req_cid;
                rq_addr <= req_addr;
            end
            if (st_q == ST_LOOK) begin
                if (need_binv) begin
                    ds_q[set_idx][alloc_way] <= DIR_I;
                    a_binv <= 1'b1;
                    a_addr <= {tag_q[set_idx][alloc_way], set_idx};
                    a_inv  <= vic_mask;
                    a_fwd  <= 1'b0;
                    a_fcid <= '0;
                    a_mem  <= 1'b0;
                end else begin
                    if (wr_en) begin
                        ds_q[set_idx][way_sel]   <= nx_st;
                        own_q[set_idx][way_sel]  <= nx_own;
                        hold_q[set_idx][way_sel] <= new_hold;
                        tag_q[set_idx][way_sel]  <= tag_in;
                    end
                    a_binv <= 1'b0;
                    a_addr <= rq_addr;
                    a_inv  <= d_inv;
                    a_fwd  <= d_fwd;
                    a_fcid <= cur_own;
                    a_mem  <= d_mem;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    a_r12_action_hold: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_ready |=> act_valid && !req_ready && $stable(act_addr)
            && $stable(act_inv_mask) && $stable(act_backinv) && $stable(act_mem_read));

    a_r5_inv_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_backinv |-> !act_inv_mask[act_cid]);

    a_r3_fwd_without_memory: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && act_fwd |-> !act_mem_read && !act_backinv);

    a_r10_backinv_other_line: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && act_backinv |-> act_addr != rq_addr && act_inv_mask != '0 && !act_mem_read);

    a_r6_writeback_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_backinv && rq_op == OP_WB |-> act_inv_mask == '0 && !act_fwd && !act_mem_read);

    a_r11_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_LOOK |-> $onehot0(hit_vec));

endmodule

// File: tb/coh_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_dir_ctrl_tb_top;

    localparam int NM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid [NM];
    logic [1:0]  req_op;
    logic [2:0]  req_cid;
    logic [11:0] req_addr;
    logic        act_ready;

    logic        req_ready [NM];
    logic        act_valid [NM];
    logic        act_backinv [NM];
    logic [11:0] act_addr [NM];
    logic [2:0]  act_cid [NM];
    logic [7:0]  act_inv [NM];
    logic        act_fwd [NM];
    logic [2:0]  act_fcid [NM];
    logic        act_mem [NM];

    for (genvar g = 0; g < NM; g++) begin : g_dut
        coh_dir_ctrl #(.SHR_MODE(g)) dut_i (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[g]), .req_ready(req_ready[g]),
            .req_op(req_op), .req_cid(req_cid), .req_addr(req_addr),
            .act_valid(act_valid[g]), .act_ready(act_ready),
            .act_backinv(act_backinv[g]), .act_addr(act_addr[g]),
            .act_cid(act_cid[g]), .act_inv_mask(act_inv[g]),
            .act_fwd(act_fwd[g]), .act_fwd_cid(act_fcid[g]),
            .act_mem_read(act_mem[g])
        );
    end

    int total = 0;
    int fails = 0;

    logic [7:0]  r_inv [NM];
    logic        r_fwd [NM];
    logic [2:0]  r_fcid [NM];
    logic        r_mem [NM];
    logic [11:0] r_addr [NM];
    int          binv_cnt [NM];
    logic [11:0] binv_addr [NM];
    logic [7:0]  binv_mask [NM];

    task automatic chk(string req, int k, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s mode%0d: actual %0h expected %0h", req, k, act, exp);
        end
    endtask

    task automatic do_one(int k);
        bit done;
        done = 1'b0;
        @(negedge clk);
        req_valid[k] = 1'b1;
        while (!req_ready[k]) @(negedge clk);
        @(negedge clk);
        req_valid[k] = 1'b0;
        while (!done) begin
            if (act_valid[k] && act_ready) begin
                if (act_backinv[k]) begin
                    binv_cnt[k]++;
                    binv_addr[k] = act_addr[k];
                    binv_mask[k] = act_inv[k];
                end else begin
                    r_inv[k]  = act_inv[k];
                    r_fwd[k]  = act_fwd[k];
                    r_fcid[k] = act_fcid[k];
                    r_mem[k]  = act_mem[k];
                    r_addr[k] = act_addr[k];
                    done = 1'b1;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic xact(logic [1:0] op, logic [2:0] cid, logic [11:0] addr);
        req_op   = op;
        req_cid  = cid;
        req_addr = addr;
        for (int k = 0; k < NM; k++) binv_cnt[k] = 0;
        fork
            do_one(0);
            do_one(1);
            do_one(2);
        join
    endtask

    // Checks the response of all three encodings.
    task automatic chk_resp(string req, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2,
                            logic efwd, logic [2:0] efcid, logic emem);
        for (int k = 0; k < NM; k++) begin
            chk({req, " inv"}, k, 32'(r_inv[k]), 32'(k == 0 ? e0 : (k == 1 ? e1 : e2)));
            chk({req, " fwd"}, k, 32'(r_fwd[k]), 32'(efwd));
            if (efwd) chk({req, " fwd_cid"}, k, 32'(r_fcid[k]), 32'(efcid));
            chk({req, " mem"}, k, 32'(r_mem[k]), 32'(emem));
            chk({req, " no backinv"}, k, 32'(binv_cnt[k]), 32'd0);
        end
    endtask

    localparam logic [1:0] RD = 2'd0, RFO = 2'd1, WB = 2'd2, EV = 2'd3;

    task automatic t_reset();
        for (int k = 0; k < NM; k++) begin
            chk("R1 ready after reset", k, 32'(req_ready[k]), 32'd1);
            chk("R1 no action after reset", k, 32'(act_valid[k]), 32'd0);
        end
    endtask

    task automatic t_read_paths();
        xact(RD, 3'd1, 12'h012);
        chk_resp("R2 read miss", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
        chk("R1 response addr", 0, 32'(r_addr[0]), 32'h012);
        xact(RD, 3'd2, 12'h012);
        chk_resp("R3 read of X", 8'h00, 8'h00, 8'h00, 1'b1, 3'd1, 1'b0);
        xact(RD, 3'd5, 12'h012);
        chk_resp("R4 read of S", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
    endtask

    task automatic t_rfo();
        // Holders {1,2,5}; pointer mode overflowed on cache 5 (R9), coarse groups 0..2 (R8).
        xact(RFO, 3'd2, 12'h012);
        chk_resp("R5 R8 R9 rfo of S", 8'h22, 8'h3B, 8'hFB, 1'b0, 3'd0, 1'b1);
        xact(RD, 3'd3, 12'h012);
        chk_resp("R5 owner after rfo", 8'h00, 8'h00, 8'h00, 1'b1, 3'd2, 1'b0);
    endtask

    task automatic t_writeback();
        xact(RD, 3'd4, 12'h023);
        chk_resp("R2 read miss B", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
        xact(WB, 3'd6, 12'h023);
        chk_resp("R6 wb non-owner", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0);
        xact(RFO, 3'd7, 12'h023);
        chk_resp("R6 R5 owner kept then rfo", 8'h10, 8'h30, 8'h10, 1'b1, 3'd4, 1'b0);
        xact(WB, 3'd7, 12'h023);
        chk_resp("R6 wb owner", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0);
        xact(RD, 3'd0, 12'h023);
        chk_resp("R6 line back to I", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
        xact(WB, 3'd3, 12'h3A3);
        chk_resp("R6 wb miss", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_evict_notice();
        xact(RD, 3'd3, 12'h033);
        xact(RD, 3'd6, 12'h033);
        chk_resp("R3 second sharer C", 8'h00, 8'h00, 8'h00, 1'b1, 3'd3, 1'b0);
        xact(EV, 3'd3, 12'h033);
        chk_resp("R7 evict notice quiet", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0);
        xact(EV, 3'd6, 12'h033);
        xact(RFO, 3'd1, 12'h033);
        chk_resp("R7 R8 last holder gone", 8'h00, 8'hCC, 8'h00, 1'b0, 3'd0, 1'b1);
    endtask

    task automatic t_dir_evict();
        xact(RD, 3'd0, 12'h100);
        xact(RD, 3'd1, 12'h200);
        xact(RD, 3'd0, 12'h100);
        chk_resp("R4 owner re-read", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
        xact(RD, 3'd2, 12'h300);
        for (int k = 0; k < NM; k++) begin
            chk("R10 one backinv", k, 32'(binv_cnt[k]), 32'd1);
            chk("R10 R11 victim addr", k, 32'(binv_addr[k]), 32'h200);
            chk("R10 victim mask", k, 32'(binv_mask[k]), (k == 1) ? 32'h03 : 32'h02);
            chk("R10 response mem", k, 32'(r_mem[k]), 32'd1);
        end
        xact(RD, 3'd3, 12'h100);
        chk_resp("R11 recent line kept", 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_prefer_free();
        xact(RD, 3'd0, 12'h011);
        xact(RD, 3'd1, 12'h111);
        xact(WB, 3'd1, 12'h111);
        xact(RD, 3'd2, 12'h211);
        chk_resp("R11 free way taken", 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
        xact(RD, 3'd5, 12'h011);
        chk_resp("R11 LRU valid line kept", 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_backpressure();
        act_ready = 1'b0;
        req_op = RD; req_cid = 3'd1; req_addr = 12'h412;
        @(negedge clk);
        req_valid[0] = 1'b1;
        @(negedge clk);
        req_valid[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 valid held", 0, 32'(act_valid[0]), 32'd1);
        chk("R12 not ready", 0, 32'(req_ready[0]), 32'd0);
        chk("R12 addr held", 0, 32'(act_addr[0]), 32'h412);
        chk("R12 mem held", 0, 32'(act_mem[0]), 32'd1);
        act_ready = 1'b1;
        @(negedge clk);
        chk("R12 released", 0, 32'(act_valid[0]), 32'd0);
        @(negedge clk);
        chk("R1 idle again", 0, 32'(req_ready[0]), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < NM; k++) req_valid[k] = 1'b0;
        req_op = 2'd0; req_cid = 3'd0; req_addr = '0;
        act_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_paths();
        t_rfo();
        t_writeback();
        t_evict_notice();
        t_dir_evict();
        t_prefer_free();
        t_backpressure();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule